// File: doc/BRIEF.md
# Word-Mapped Byte UART Register Block

This block is a bus slave that puts a small UART front end behind four 32-bit word registers: receive data, transmit data, status and control. Bytes from a serial receiver come in on a valid/ready byte stream. They are held in a receive FIFO, 8 entries deep by default, until the host pulls them out through the receive-data register. A host write to the transmit-data register places the low byte on a valid/ready output stream, where a serial transmitter takes it. Bit timing, baud generation, parity and framing checks belong to the neighbouring serializer and are not part of this block.

The host reaches the registers with a single-cycle access strobe. The byte address is shifted right by two to pick the word. Read data is combinational from the state before the clock edge, and every side effect of the access lands on that edge. One level-sensitive interrupt line combines a sticky event flag in the status word with an enable bit in the control word.

Top module: `wuart_regs`

## Requirements
- R1: The word index is the byte address shifted right by two: index 0 is receive data, 1 transmit data, 2 status, 3 control. After reset, status reads 0x00000004, control reads 0, the interrupt is low and the transmit stream is idle.
- R2: Reading receive data while the FIFO holds bytes returns the oldest byte in bits 7:0 with upper bits zero and removes that byte. Bytes come out in arrival order, including when a push and a pop fall in the same cycle.
- R3: `rx_ready` is high exactly while occupancy is below the depth and no receive reset is being written. A byte offered while the FIFO is full is not stored. Status bit1 reads 1 exactly when occupancy equals the depth.
- R4: Reading receive data while the FIFO is empty returns the byte stored at the current read slot and changes neither occupancy nor pointer.
- R5: A control write with bit1 set empties the FIFO and resets its pointer on the same edge, and drops any byte offered in that cycle. Control reads back the full 32-bit value last written.
- R6: Status bit0 is 1 when occupancy is nonzero. Bit3 is 1 while a transmit byte waits for `tx_ready`, and bit2 is its inverse. Bits 5, 6, 7 and 31:8 read 0.
- R7: A transmit-data write raises `tx_valid` on the next cycle with the low 8 bits of the write on `tx_data`. Both hold until `tx_ready` is seen. A control write with bit0 set drops a pending byte. Transmit data reads back the last 32-bit value written.
- R8: Status bit4 (event pending) is set after any access or stream cycle that leaves the FIFO non-empty, and after any transmit-data write. A status read clears it unless the FIFO is still non-empty after that cycle.
- R9: `irq` equals status bit4 ANDed with control bit4.
- R10: Writes to the status register and to the receive-data register change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe for one cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| rx_valid | input | 1 | Incoming byte present |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | FIFO can take a byte |
| tx_valid | output | 1 | Outgoing byte present |
| tx_data | output | 8 | Outgoing byte |
| tx_ready | input | 1 | Downstream took the byte |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block at its default parameters: a depth of 8, 32-bit words and a 4-bit byte address. With these values the FIFO fills within a few cycles, so the full boundary, the refused byte and pointer wrap past slot 7 are all reachable in a short run. An empty read at a read slot that still holds an old byte is also reachable. A behavioural model built on a queue tracks every output on every cycle, and it covers pops and pushes that fall in the same cycle as well as interrupt gating in both enable states.

// File: rtl/wuart_pkg.sv
package wuart_pkg;
  localparam int REG_W  = 32;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 2;

  typedef enum logic [IDX_W-1:0] {
    IDX_RXD  = 2'd0,
    IDX_TXD  = 2'd1,
    IDX_STAT = 2'd2,
    IDX_CTRL = 2'd3
  } reg_idx_e;

  // status bit positions
  localparam int ST_RX_AVAIL = 0;
  localparam int ST_RX_FULL  = 1;
  localparam int ST_TX_EMPTY = 2;
  localparam int ST_TX_FULL  = 3;
  localparam int ST_PEND     = 4;

  // control bit positions
  localparam int CT_TX_CLR = 0;
  localparam int CT_RX_CLR = 1;
  localparam int CT_IE     = 4;

  function automatic reg_idx_e word_index(input logic [IDX_W+1:0] byte_addr);
    logic [IDX_W+1:0] shifted;
    shifted = byte_addr >> 2;
    return reg_idx_e'(shifted[IDX_W-1:0]);
  endfunction

  function automatic logic [REG_W-1:0] status_word(input logic avail, input logic full,
                                                   input logic pend, input logic tx_busy);
    logic [REG_W-1:0] s;
    s = '0;
    s[ST_RX_AVAIL] = avail;
    s[ST_RX_FULL]  = full;
    s[ST_TX_EMPTY] = ~tx_busy;
    s[ST_TX_FULL]  = tx_busy;
    s[ST_PEND]     = pend;
    return s;
  endfunction
endpackage

// File: rtl/wuart_rx_fifo.sv
module wuart_rx_fifo #(
  parameter int DEPTH  = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  input  logic              pop_req,
  input  logic              clr,
  output logic [BYTE_W-1:0] head_data,
  output logic              avail,
  output logic              full,
  output logic              avail_next
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = PTR_W + 1;
  localparam logic [OCC_W-1:0] FULL_CNT = OCC_W'(DEPTH);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr;
  logic [OCC_W-1:0]  occ;
  logic [OCC_W-1:0]  occ_nxt;
  logic              push_evt;
  logic              pop_evt;
  logic [PTR_W-1:0]  rd_slot;

  function automatic logic [PTR_W-1:0] oldest_slot(input logic [PTR_W-1:0] wp,
                                                   input logic [OCC_W-1:0] cnt);
    logic [OCC_W-1:0] diff;
    diff = {1'b0, wp} - cnt;
    return diff[PTR_W-1:0];
  endfunction

  function automatic logic [OCC_W-1:0] next_count(input logic [OCC_W-1:0] cnt,
                                                  input logic inc, input logic dec,
                                                  input logic wipe);
    if (wipe) return '0;
    return cnt + OCC_W'(inc) - OCC_W'(dec);
  endfunction

  assign in_ready   = (occ < FULL_CNT) && !clr;
  assign push_evt   = in_valid && in_ready;
  assign pop_evt    = pop_req && (occ != '0) && !clr;
  assign rd_slot    = oldest_slot(wr_ptr, occ);
  assign head_data  = mem[rd_slot];
  assign avail      = (occ != '0);
  assign full       = (occ == FULL_CNT);
  assign occ_nxt    = next_count(occ, push_evt, pop_evt, clr);
  assign avail_next = (occ_nxt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      occ    <= '0;
    end else begin
      occ <= occ_nxt;
      if (clr) wr_ptr <= '0;
      else if (push_evt) wr_ptr <= wr_ptr + PTR_W'(1);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[g] <= '0;
      else if (push_evt && (wr_ptr == PTR_W'(g))) mem[g] <= in_data;
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt |-> (occ < FULL_CNT));
  p_pop_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_evt && !push_evt) |=> (occ == $past(occ) - OCC_W'(1)));
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (occ == '0) && (wr_ptr == '0));
  p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !avail && !in_valid && !clr) |=> !avail && $stable(wr_ptr));
endmodule

// File: rtl/wuart_tx_port.sv
module wuart_tx_port #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              clr,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (clr) begin
      out_valid <= 1'b0;
    end else if (wr) begin
      out_valid <= 1'b1;
      out_data  <= wbyte;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !wr && !clr) |=> out_valid && $stable(out_data));
  p_tx_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr) |=> out_valid && (out_data == $past(wbyte)));
endmodule

// File: rtl/wuart_irq.sv
module wuart_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_avail_next,
  input  logic tx_wr,
  input  logic stat_rd,
  input  logic ie,
  output logic pend,
  output logic irq
);
  function automatic logic pend_next(input logic cur, input logic rx_nz,
                                     input logic tx_ev, input logic ack);
    return rx_nz || tx_ev || (cur && !ack);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_next(pend, rx_avail_next, tx_wr, stat_rd);
  end

  assign irq = pend && ie;

  p_pend_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> pend);
  p_pend_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !rx_avail_next && !tx_wr) |=> !pend);
endmodule

// File: rtl/wuart_regs.sv
module wuart_regs
  import wuart_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready,
  output logic              irq
);
  reg_idx_e          idx;
  logic              wr_acc, rd_acc;
  logic              rx_pop_req, stat_rd, tx_wr, ctrl_wr;
  logic              rx_clr, tx_clr;
  logic [REG_W-1:0]  ctrl_q, txreg_q;
  logic [BYTE_W-1:0] head_byte;
  logic              rx_avail, rx_full, rx_avail_nxt, pend;

  assign idx        = word_index(bus_addr[IDX_W+1:0]);
  assign wr_acc     = bus_en && bus_we;
  assign rd_acc     = bus_en && !bus_we;
  assign rx_pop_req = rd_acc && (idx == IDX_RXD);
  assign stat_rd    = rd_acc && (idx == IDX_STAT);
  assign tx_wr      = wr_acc && (idx == IDX_TXD);
  assign ctrl_wr    = wr_acc && (idx == IDX_CTRL);
  assign rx_clr     = ctrl_wr && bus_wdata[CT_RX_CLR];
  assign tx_clr     = ctrl_wr && bus_wdata[CT_TX_CLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      txreg_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q  <= bus_wdata;
      if (tx_wr)   txreg_q <= bus_wdata;
    end
  end

  wuart_rx_fifo #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) i_rx (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_valid), .in_data(rx_data), .in_ready(rx_ready),
    .pop_req(rx_pop_req), .clr(rx_clr),
    .head_data(head_byte), .avail(rx_avail), .full(rx_full),
    .avail_next(rx_avail_nxt)
  );

  wuart_tx_port #(.BYTE_W(BYTE_W)) i_tx (
    .clk(clk), .rst_n(rst_n),
    .wr(tx_wr), .wbyte(bus_wdata[BYTE_W-1:0]), .clr(tx_clr),
    .out_ready(tx_ready), .out_valid(tx_valid), .out_data(tx_data)
  );

  wuart_irq i_irq (
    .clk(clk), .rst_n(rst_n),
    .rx_avail_next(rx_avail_nxt), .tx_wr(tx_wr), .stat_rd(stat_rd),
    .ie(ctrl_q[CT_IE]), .pend(pend), .irq(irq)
  );

  always_comb begin
    unique case (idx)
      IDX_RXD:  bus_rdata = {{(REG_W-BYTE_W){1'b0}}, head_byte};
      IDX_TXD:  bus_rdata = txreg_q;
      IDX_STAT: bus_rdata = status_word(rx_avail, rx_full, pend, tx_valid);
      default:  bus_rdata = ctrl_q;
    endcase
  end

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl_q[CT_IE]);
  p_tx_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |-> (bus_rdata[ST_TX_EMPTY] != bus_rdata[ST_TX_FULL]) && (bus_rdata[7:5] == 3'b000));
  p_status_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && (idx == IDX_STAT) && !rx_valid && !pend && !tx_valid) |=> !pend && !tx_valid);
  p_full_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !rx_ready);
endmodule

// File: tb/test_wuart_regs.sv
`timescale 1ns/1ps
module test_wuart_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_valid, irq;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;

  always #2.5 clk = ~clk;

  wuart_regs i_wuart_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .irq(irq)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  string tag = "R1";

  // behavioural reference model
  byte unsigned q[$];
  byte unsigned m_mem[8];
  int          m_wcnt = 0;
  bit          m_pend = 0, m_txv = 0;
  logic [31:0] m_ctrl = 0, m_txreg = 0;
  logic [7:0]  m_txd = 0;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_status();
    logic [31:0] s = 0;
    s[0] = q.size() != 0;
    s[1] = q.size() == 8;
    s[2] = !m_txv;
    s[3] = m_txv;
    s[4] = m_pend;
    return s;
  endfunction

  task automatic cyc(bit en, bit we, int a, logic [31:0] wd, bit rv, byte unsigned rd, bit tr);
    int  idx;
    bit  rclr, tclr, txw, srd, rrx, rdy_e;
    bus_en = en; bus_we = we; bus_addr = a[3:0]; bus_wdata = wd;
    rx_valid = rv; rx_data = rd; tx_ready = tr;
    #1;
    idx  = (a >> 2) & 3;
    rclr = en && we && idx == 3 && wd[1];
    tclr = en && we && idx == 3 && wd[0];
    txw  = en && we && idx == 1;
    srd  = en && !we && idx == 2;
    rrx  = en && !we && idx == 0;
    rdy_e = (q.size() < 8) && !rclr;
    chk("rx_ready", rx_ready, rdy_e);
    chk("irq", irq, m_pend && m_ctrl[4]);
    chk("tx_valid", tx_valid, m_txv);
    if (m_txv) chk("tx_data", tx_data, m_txd);
    if (en && !we) begin
      case (idx)
        0: chk("rxdata", bus_rdata, q.size() ? q[0] : m_mem[m_wcnt % 8]);
        1: chk("txreg", bus_rdata, m_txreg);
        2: chk("status", bus_rdata, m_status());
        default: chk("ctrl", bus_rdata, m_ctrl);
      endcase
    end
    // state update as of the coming edge
    if (rclr) begin
      q.delete(); m_wcnt = 0;
    end else begin
      if (rrx && q.size() > 0) void'(q.pop_front());
      if (rv && rdy_e) begin
        m_mem[m_wcnt % 8] = rd; m_wcnt++; q.push_back(rd);
      end
    end
    m_pend = (q.size() != 0) || txw || (m_pend && !srd);
    if (en && we && idx == 3) m_ctrl = wd;
    if (txw) m_txreg = wd;
    if (tclr) m_txv = 0;
    else if (txw) begin m_txv = 1; m_txd = wd[7:0]; end
    else if (m_txv && tr) m_txv = 0;
    @(negedge clk);
  endtask

  task automatic idle();           cyc(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic rd(int a);        cyc(1, 0, a, 0, 0, 0, 0); endtask
  task automatic wr(int a, logic [31:0] d); cyc(1, 1, a, d, 0, 0, 0); endtask
  task automatic push(byte unsigned b);     cyc(0, 0, 0, 0, 1, b, 0); endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R1"; rd(8); rd(12); rd(4); idle();
    tag = "R6"; rd(8);
    tag = "R2";
    push(8'h11); push(8'h22); push(8'h33);
    rd(0); rd(0); rd(0); rd(8);
    tag = "R2"; // pop and push together
    push(8'h44); cyc(1, 0, 0, 0, 1, 8'h55, 0); rd(0); rd(8);
    tag = "R3";
    for (int i = 0; i < 10; i++) push(8'(8'hA0 + i));
    rd(8);
    tag = "R3"; cyc(1, 0, 0, 0, 1, 8'hEE, 0); rd(8);
    tag = "R9"; wr(12, 32'h10); idle(); rd(8);
    for (int i = 0; i < 8; i++) rd(0);
    tag = "R8"; rd(8); idle();
    tag = "R4"; rd(0); rd(0); rd(8);
    tag = "R5";
    push(8'h61); push(8'h62); cyc(1, 1, 12, 32'h0000_0012, 1, 8'h63, 0);
    rd(8); rd(12); rd(0); push(8'h64); rd(0);
    tag = "R7";
    wr(4, 32'h0000_01A5); rd(8); idle(); rd(4);
    cyc(0, 0, 0, 0, 0, 0, 1); rd(8);
    wr(4, 32'h77); wr(12, 32'h11); rd(8);
    tag = "R8"; wr(12, 32'h10); wr(4, 32'h3C); rd(8); rd(8);
    cyc(0, 0, 0, 0, 0, 0, 1);
    tag = "R9"; wr(12, 32'h0); wr(4, 32'h5A); idle(); rd(8);
    cyc(0, 0, 0, 0, 0, 0, 1);
    tag = "R10"; wr(8, 32'hFFFF_FFFF); rd(8); wr(0, 32'h99); rd(8); rd(0);
    tag = "R1"; rd(9); rd(15);
    repeat (3) idle();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule